// File: doc/BRIEF.md
# MSI to Adapter Indicator Bit Setter

This block takes message-signalled interrupt writes aimed at a set of PCI functions and turns each one into two bit sets in memory. The first sets one bit in the function's indicator bit array. The second sets one bit in a summary bit array that several functions can share. The upper half of the write data selects the function and the lower half selects the vector. Bits are numbered big-endian inside each byte, so bit 0 of a byte is its most significant bit. Each function has a programmable bit offset into its indicator array and into the summary array.

Memory is reached through a byte read-modify-write port. That port performs an atomic OR and returns the byte as it was before the OR. An adapter interrupt pulse, tagged with the function's interruption subclass, is raised only when the summary byte read back as zero. Software therefore gets one interrupt per summary byte until it clears that byte. A write whose index names no bound function produces an error event instead of a memory access. A write to a bound function that is not enabled is dropped. Reads of the MSI region return ones in the low 32 bits.

Top module: `msi_ind_notify`

## Requirements
- R1: After reset `msi_ready` is 1, and `mem_req`, `irq_pulse`, `err_valid` and `rsp_valid` are 0.
- R2: An accepted write splits `msi_data` into a function index, taken from bits [31:16], and a vector number, taken from bits [15:0].
- R3: The indicator access goes to byte address `ind_base + (ind_off + vector) / 8` with mask `8'h80 >> ((ind_off + vector) % 8)`.
- R4: The summary access goes to byte address `sum_base + sum_off / 8` with mask `8'h80 >> (sum_off % 8)`.
- R5: The indicator access is acknowledged before the summary access is requested. `msi_ready` is 0 from the cycle after a write to an enabled function is accepted until the cycle after the summary acknowledge.
- R6: While `mem_req` is 1 and `mem_ack` is 0, `mem_addr` and `mem_mask` hold their values. `mem_mask` always has exactly one bit set.
- R7: In the cycle after the summary acknowledge, `irq_pulse` is 1 for one cycle exactly when `mem_old` was 8'h00. `irq_isc` then carries the function's subclass.
- R8: A write whose index is at least NUM_FN, or whose function's `fn_bound` bit is 0, makes no memory access. In the next cycle it produces a one-cycle `err_valid` with `err_code` = ERR_NO_MSI, `err_index` = the index, `err_addr` = `msi_addr` and `err_info` = vector << 16.
- R9: A write to a bound function whose `fn_enable` bit is 0 produces no memory access, no interrupt and no error event.
- R10: An accepted read (`msi_write` = 0) gives `rsp_valid` for one cycle in the next cycle, with `rsp_data[31:0]` all ones and the upper bits zero. It makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msi_valid | input | 1 | MSI region access present |
| msi_ready | output | 1 | Access accepted when high together with msi_valid |
| msi_write | input | 1 | 1 for a write, 0 for a read |
| msi_addr | input | AW | Target address of the access |
| msi_data | input | DATA_W | Write data: function index in the upper half, vector in the lower half |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | RSP_W | Read response data |
| fn_bound | input | NUM_FN | Function slot holds a function |
| fn_enable | input | NUM_FN | Function is in the enabled state |
| fn_isc | input | NUM_FN*ISC_W | Interruption subclass for each function |
| fn_ind_base | input | NUM_FN*AW | Indicator array byte base for each function |
| fn_ind_off | input | NUM_FN*OFF_W | Indicator bit offset for each function |
| fn_sum_base | input | NUM_FN*AW | Summary array byte base for each function |
| fn_sum_off | input | NUM_FN*OFF_W | Summary bit offset for each function |
| mem_req | output | 1 | Byte OR request |
| mem_addr | output | AW | Byte address |
| mem_mask | output | 8 | Bits to OR into the byte |
| mem_ack | input | 1 | Request completed this cycle |
| mem_old | input | 8 | Byte value before the OR, valid with mem_ack |
| irq_pulse | output | 1 | Adapter interrupt strobe |
| irq_isc | output | ISC_W | Subclass of the interrupt |
| err_valid | output | 1 | Error event strobe |
| err_code | output | 16 | Error event code |
| err_index | output | IDX_W | Function index of the failed write |
| err_addr | output | AW | Target address of the failed write |
| err_info | output | 32 | Vector number shifted into its field |

## Verification
The bench builds the block with four function slots. Slot 0 is enabled with zero offsets. Slot 1 is bound but disabled. Slot 2 is unbound. Slot 3 is enabled with indicator offset 13 and summary offset 21, so bit positions cross byte boundaries and land at non-zero bit numbers inside a byte. An index of 9 lies beyond the table and exercises the out-of-range error path. The memory model acknowledges after zero, one or two wait cycles in rotation, which exercises the hold-until-acknowledge rule and the stall of a second write queued behind the first.

// File: rtl/msi_ind_pkg.sv
// Package: shared types for the MSI indicator bit setter.
// Assumes nothing beyond standard SystemVerilog.
package msi_ind_pkg;

    // Sequencer phase: idle, indicator byte update, summary byte update.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_IND  = 2'd1,
        PH_SUM  = 2'd2
    } msi_phase_e;

    // Value returned by a read of the MSI region, low word all ones.
    function automatic logic [63:0] read_pattern();
        return 64'h0000_0000_FFFF_FFFF;
    endfunction

endpackage

// File: rtl/msi_bit_locator.sv
// Module: msi_bit_locator
// Turns a byte base address plus a bit position (offset + vector) into the
// byte address that holds the bit and a one-hot mask for it. Bit 0 of a
// byte is its most significant bit.
// Assumes the byte index (bit position / 8) fits in AW bits.
module msi_bit_locator #(
    parameter int AW    = 32,
    parameter int OFF_W = 16,
    parameter int VEC_W = 16,
    localparam int POS_W = ((OFF_W > VEC_W) ? OFF_W : VEC_W) + 1
) (
    input  logic [AW-1:0]    base,
    input  logic [OFF_W-1:0] bit_off,
    input  logic [VEC_W-1:0] vec,
    output logic [AW-1:0]    byte_addr,
    output logic [7:0]       bit_mask
);

    logic [POS_W-1:0] bit_pos;

    // Absolute bit position within the array.
    always_comb bit_pos = POS_W'(bit_off) + POS_W'(vec);

    // Byte holding the bit, and the MSB-first mask within it.
    always_comb begin
        byte_addr = base + AW'(bit_pos[POS_W-1:3]);
        bit_mask  = 8'h80 >> bit_pos[2:0];
    end

endmodule

// File: rtl/msi_fn_lookup.sv
// Module: msi_fn_lookup
// Selects one function's settings from the flattened per-function tables by
// index. An index at or above NUM_FN reports no function.
// Assumes the tables are stable while a write is being accepted.
module msi_fn_lookup #(
    parameter int NUM_FN = 4,
    parameter int IDX_W  = 16,
    parameter int AW     = 32,
    parameter int OFF_W  = 16,
    parameter int ISC_W  = 3
) (
    input  logic [IDX_W-1:0]        idx,
    input  logic [NUM_FN-1:0]       fn_bound,
    input  logic [NUM_FN-1:0]       fn_enable,
    input  logic [NUM_FN*ISC_W-1:0] fn_isc,
    input  logic [NUM_FN*AW-1:0]    fn_ind_base,
    input  logic [NUM_FN*OFF_W-1:0] fn_ind_off,
    input  logic [NUM_FN*AW-1:0]    fn_sum_base,
    input  logic [NUM_FN*OFF_W-1:0] fn_sum_off,
    output logic                    sel_bound,
    output logic                    sel_enable,
    output logic [ISC_W-1:0]        sel_isc,
    output logic [AW-1:0]           sel_ind_base,
    output logic [OFF_W-1:0]        sel_ind_off,
    output logic [AW-1:0]           sel_sum_base,
    output logic [OFF_W-1:0]        sel_sum_off
);

    logic [ISC_W-1:0] isc_a      [NUM_FN];
    logic [AW-1:0]    ind_base_a [NUM_FN];
    logic [OFF_W-1:0] ind_off_a  [NUM_FN];
    logic [AW-1:0]    sum_base_a [NUM_FN];
    logic [OFF_W-1:0] sum_off_a  [NUM_FN];

    // Unpack each slot of the flattened tables.
    for (genvar g = 0; g < NUM_FN; g++) begin : g_slot
        assign isc_a[g]      = fn_isc[g*ISC_W +: ISC_W];
        assign ind_base_a[g] = fn_ind_base[g*AW +: AW];
        assign ind_off_a[g]  = fn_ind_off[g*OFF_W +: OFF_W];
        assign sum_base_a[g] = fn_sum_base[g*AW +: AW];
        assign sum_off_a[g]  = fn_sum_off[g*OFF_W +: OFF_W];
    end

    // Index match; defaults describe "no function".
    always_comb begin
        sel_bound    = 1'b0;
        sel_enable   = 1'b0;
        sel_isc      = '0;
        sel_ind_base = '0;
        sel_ind_off  = '0;
        sel_sum_base = '0;
        sel_sum_off  = '0;
        for (int i = 0; i < NUM_FN; i++) begin
            if (idx == IDX_W'(i)) begin
                sel_bound    = fn_bound[i];
                sel_enable   = fn_enable[i];
                sel_isc      = isc_a[i];
                sel_ind_base = ind_base_a[i];
                sel_ind_off  = ind_off_a[i];
                sel_sum_base = sum_base_a[i];
                sel_sum_off  = sum_off_a[i];
            end
        end
    end

endmodule

// File: rtl/msi_ind_seq.sv
// Module: msi_ind_seq
// Accepts MSI accesses and sequences the two byte OR operations: indicator
// first, then summary. It raises the interrupt when the old summary byte was
// zero, emits error events for writes with no function, and answers reads.
// Assumes the memory port keeps mem_old valid in the cycle mem_ack is high.
module msi_ind_seq
    import msi_ind_pkg::*;
#(
    parameter int          AW          = 32,
    parameter int          IDX_W       = 16,
    parameter int          VEC_W       = 16,
    parameter int          ISC_W       = 3,
    parameter int          RSP_W       = 64,
    parameter int          ERR_VEC_LSB = 16,
    parameter logic [15:0] ERR_NO_MSI  = 16'h0031
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msi_valid,
    output logic             msi_ready,
    input  logic             msi_write,
    input  logic [AW-1:0]    msi_addr,
    input  logic [IDX_W-1:0] idx,
    input  logic [VEC_W-1:0] vec,
    input  logic             fn_hit,
    input  logic             fn_en,
    input  logic [ISC_W-1:0] fn_isc,
    input  logic [AW-1:0]    ind_addr,
    input  logic [7:0]       ind_mask,
    input  logic [AW-1:0]    sum_addr,
    input  logic [7:0]       sum_mask,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    output logic [7:0]       mem_mask,
    input  logic             mem_ack,
    input  logic [7:0]       mem_old,
    output logic             irq_pulse,
    output logic [ISC_W-1:0] irq_isc,
    output logic             err_valid,
    output logic [15:0]      err_code,
    output logic [IDX_W-1:0] err_index,
    output logic [AW-1:0]    err_addr,
    output logic [31:0]      err_info,
    output logic             rsp_valid,
    output logic [RSP_W-1:0] rsp_data,
    output logic             sum_phase
);

    msi_phase_e       phase;
    logic [AW-1:0]    ind_addr_q;
    logic [7:0]       ind_mask_q;
    logic [AW-1:0]    sum_addr_q;
    logic [7:0]       sum_mask_q;
    logic [ISC_W-1:0] isc_q;
    logic             accept;

    // Handshake at the MSI edge.
    always_comb begin
        msi_ready = (phase == PH_IDLE);
        accept    = msi_valid && msi_ready;
    end

    // Memory request drive, selecting the captured byte for the phase.
    always_comb begin
        mem_req   = (phase != PH_IDLE);
        sum_phase = (phase == PH_SUM);
        mem_addr  = sum_phase ? sum_addr_q : ind_addr_q;
        mem_mask  = sum_phase ? sum_mask_q : ind_mask_q;
        err_code  = ERR_NO_MSI;
        rsp_data  = RSP_W'(read_pattern());
    end

    // Phase sequencing, capture of the access, and strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            ind_addr_q <= '0;
            ind_mask_q <= 8'h80;
            sum_addr_q <= '0;
            sum_mask_q <= 8'h80;
            isc_q      <= '0;
            irq_pulse  <= 1'b0;
            irq_isc    <= '0;
            err_valid  <= 1'b0;
            err_index  <= '0;
            err_addr   <= '0;
            err_info   <= '0;
            rsp_valid  <= 1'b0;
        end else begin
            irq_pulse <= 1'b0;
            err_valid <= 1'b0;
            rsp_valid <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        if (!msi_write) begin
                            rsp_valid <= 1'b1;
                        end else if (!fn_hit) begin
                            err_valid <= 1'b1;
                            err_index <= idx;
                            err_addr  <= msi_addr;
                            err_info  <= 32'(vec) << ERR_VEC_LSB;
                        end else if (fn_en) begin
                            ind_addr_q <= ind_addr;
                            ind_mask_q <= ind_mask;
                            sum_addr_q <= sum_addr;
                            sum_mask_q <= sum_mask;
                            isc_q      <= fn_isc;
                            phase      <= PH_IND;
                        end
                    end
                end
                PH_IND: begin
                    if (mem_ack) phase <= PH_SUM;
                end
                PH_SUM: begin
                    if (mem_ack) begin
                        irq_pulse <= (mem_old == 8'h00);
                        irq_isc   <= isc_q;
                        phase     <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/msi_ind_notify.sv
// Module: msi_ind_notify (top)
// MSI write to adapter indicator bit setter. It decodes the function index
// and vector, locates the indicator and summary bits, and runs the two byte
// OR operations through the sequencer.
// Assumes the per-function tables change only while msi_ready is low or no
// access is offered.
module msi_ind_notify
    import msi_ind_pkg::*;
#(
    parameter int          AW          = 32,
    parameter int          DATA_W      = 32,
    parameter int          VEC_W       = 16,
    parameter int          NUM_FN      = 4,
    parameter int          OFF_W       = 16,
    parameter int          ISC_W       = 3,
    parameter int          RSP_W       = 64,
    parameter int          ERR_VEC_LSB = 16,
    parameter logic [15:0] ERR_NO_MSI  = 16'h0031,
    localparam int         IDX_W       = DATA_W - VEC_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    msi_valid,
    output logic                    msi_ready,
    input  logic                    msi_write,
    input  logic [AW-1:0]           msi_addr,
    input  logic [DATA_W-1:0]       msi_data,
    output logic                    rsp_valid,
    output logic [RSP_W-1:0]        rsp_data,
    input  logic [NUM_FN-1:0]       fn_bound,
    input  logic [NUM_FN-1:0]       fn_enable,
    input  logic [NUM_FN*ISC_W-1:0] fn_isc,
    input  logic [NUM_FN*AW-1:0]    fn_ind_base,
    input  logic [NUM_FN*OFF_W-1:0] fn_ind_off,
    input  logic [NUM_FN*AW-1:0]    fn_sum_base,
    input  logic [NUM_FN*OFF_W-1:0] fn_sum_off,
    output logic                    mem_req,
    output logic [AW-1:0]           mem_addr,
    output logic [7:0]              mem_mask,
    input  logic                    mem_ack,
    input  logic [7:0]              mem_old,
    output logic                    irq_pulse,
    output logic [ISC_W-1:0]        irq_isc,
    output logic                    err_valid,
    output logic [15:0]             err_code,
    output logic [IDX_W-1:0]        err_index,
    output logic [AW-1:0]           err_addr,
    output logic [31:0]             err_info
);

    localparam int N_LOC = 2;   // 0: indicator array, 1: summary array

    logic [IDX_W-1:0] wr_idx;
    logic [VEC_W-1:0] wr_vec;
    logic             sel_bound, sel_enable;
    logic [ISC_W-1:0] sel_isc;
    logic [AW-1:0]    sel_ind_base, sel_sum_base;
    logic [OFF_W-1:0] sel_ind_off, sel_sum_off;
    logic [AW-1:0]    loc_base  [N_LOC];
    logic [OFF_W-1:0] loc_off   [N_LOC];
    logic [VEC_W-1:0] loc_vec   [N_LOC];
    logic [AW-1:0]    loc_addr  [N_LOC];
    logic [7:0]       loc_mask  [N_LOC];
    logic             sum_phase;

    // Split of the write data into function index and vector.
    always_comb begin
        wr_idx = msi_data[DATA_W-1:VEC_W];
        wr_vec = msi_data[VEC_W-1:0];
    end

    msi_fn_lookup #(
        .NUM_FN (NUM_FN),
        .IDX_W  (IDX_W),
        .AW     (AW),
        .OFF_W  (OFF_W),
        .ISC_W  (ISC_W)
    ) u_lookup (
        .idx          (wr_idx),
        .fn_bound     (fn_bound),
        .fn_enable    (fn_enable),
        .fn_isc       (fn_isc),
        .fn_ind_base  (fn_ind_base),
        .fn_ind_off   (fn_ind_off),
        .fn_sum_base  (fn_sum_base),
        .fn_sum_off   (fn_sum_off),
        .sel_bound    (sel_bound),
        .sel_enable   (sel_enable),
        .sel_isc      (sel_isc),
        .sel_ind_base (sel_ind_base),
        .sel_ind_off  (sel_ind_off),
        .sel_sum_base (sel_sum_base),
        .sel_sum_off  (sel_sum_off)
    );

    // Operand selection for the two locators; only the indicator adds the vector.
    always_comb begin
        loc_base[0] = sel_ind_base;
        loc_off[0]  = sel_ind_off;
        loc_vec[0]  = wr_vec;
        loc_base[1] = sel_sum_base;
        loc_off[1]  = sel_sum_off;
        loc_vec[1]  = '0;
    end

    for (genvar g = 0; g < N_LOC; g++) begin : g_loc
        msi_bit_locator #(
            .AW    (AW),
            .OFF_W (OFF_W),
            .VEC_W (VEC_W)
        ) u_loc (
            .base      (loc_base[g]),
            .bit_off   (loc_off[g]),
            .vec       (loc_vec[g]),
            .byte_addr (loc_addr[g]),
            .bit_mask  (loc_mask[g])
        );
    end

    msi_ind_seq #(
        .AW          (AW),
        .IDX_W       (IDX_W),
        .VEC_W       (VEC_W),
        .ISC_W       (ISC_W),
        .RSP_W       (RSP_W),
        .ERR_VEC_LSB (ERR_VEC_LSB),
        .ERR_NO_MSI  (ERR_NO_MSI)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .msi_valid (msi_valid),
        .msi_ready (msi_ready),
        .msi_write (msi_write),
        .msi_addr  (msi_addr),
        .idx       (wr_idx),
        .vec       (wr_vec),
        .fn_hit    (sel_bound),
        .fn_en     (sel_enable),
        .fn_isc    (sel_isc),
        .ind_addr  (loc_addr[0]),
        .ind_mask  (loc_mask[0]),
        .sum_addr  (loc_addr[1]),
        .sum_mask  (loc_mask[1]),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_mask  (mem_mask),
        .mem_ack   (mem_ack),
        .mem_old   (mem_old),
        .irq_pulse (irq_pulse),
        .irq_isc   (irq_isc),
        .err_valid (err_valid),
        .err_code  (err_code),
        .err_index (err_index),
        .err_addr  (err_addr),
        .err_info  (err_info),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .sum_phase (sum_phase)
    );

endmodule

// File: rtl/msi_ind_notify_chk.sv
// Module: msi_ind_notify_chk
// Protocol and ordering properties of msi_ind_notify, bound to the top.
module msi_ind_notify_chk #(
    parameter int AW    = 32,
    parameter int RSP_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             msi_ready,
    input logic             mem_req,
    input logic             mem_ack,
    input logic [AW-1:0]    mem_addr,
    input logic [7:0]       mem_mask,
    input logic [7:0]       mem_old,
    input logic             irq_pulse,
    input logic             err_valid,
    input logic             rsp_valid,
    input logic [RSP_W-1:0] rsp_data,
    input logic             sum_phase
);

    // R5: no new access is taken while a byte update is outstanding.
    a_r5_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !msi_ready);

    // R5: an acknowledged indicator access is followed by the summary access.
    a_r5_ind_then_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !sum_phase) |=> (mem_req && sum_phase));

    // R6: the request holds address and mask until acknowledged.
    a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_mask)));

    // R6: exactly one bit is set per access.
    a_r6_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_mask) == 1));

    // R7: an interrupt only follows a summary acknowledge with a zero old byte.
    a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(mem_req && mem_ack && sum_phase && (mem_old == 8'h00)));

    // R7: the interrupt strobe lasts one cycle.
    a_r7_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    // R8: an error event never coincides with a memory access.
    a_r8_err_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> !mem_req);

    // R10: read responses carry ones in the low word and zeros above.
    a_r10_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_data[31:0] == 32'hFFFF_FFFF && rsp_data[RSP_W-1:32] == '0));

endmodule

bind msi_ind_notify msi_ind_notify_chk #(
    .AW    (AW),
    .RSP_W (RSP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .msi_ready (msi_ready),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_mask  (mem_mask),
    .mem_old   (mem_old),
    .irq_pulse (irq_pulse),
    .err_valid (err_valid),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .sum_phase (sum_phase)
);

// File: tb/msi_ind_notify_test.sv
// Bench for msi_ind_notify: a behavioural reference model compared at every
// falling edge, plus a memory model that performs the byte OR operations.
module msi_ind_notify_test;

    localparam int AW = 32, NF = 4, ISC_W = 3, OFF_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              msi_valid = 1'b0;
    logic              msi_ready;
    logic              msi_write = 1'b0;
    logic [AW-1:0]     msi_addr = '0;
    logic [31:0]       msi_data = '0;
    logic              rsp_valid;
    logic [63:0]       rsp_data;
    logic [NF-1:0]     fn_bound  = 4'b1011;
    logic [NF-1:0]     fn_enable = 4'b1001;
    logic [NF*ISC_W-1:0] fn_isc  = {3'd7, 3'd0, 3'd2, 3'd5};
    logic [NF*AW-1:0]  fn_ind_base = {32'h4000, 32'h0, 32'h3000, 32'h1000};
    logic [NF*OFF_W-1:0] fn_ind_off = {16'd13, 16'd0, 16'd0, 16'd0};
    logic [NF*AW-1:0]  fn_sum_base = {32'h5000, 32'h0, 32'h3800, 32'h2000};
    logic [NF*OFF_W-1:0] fn_sum_off = {16'd21, 16'd0, 16'd0, 16'd0};
    logic              mem_req;
    logic [AW-1:0]     mem_addr;
    logic [7:0]        mem_mask;
    logic              mem_ack = 1'b0;
    logic [7:0]        mem_old = 8'h5A;
    logic              irq_pulse;
    logic [ISC_W-1:0]  irq_isc;
    logic              err_valid;
    logic [15:0]       err_code;
    logic [15:0]       err_index;
    logic [AW-1:0]     err_addr;
    logic [31:0]       err_info;

    always #10 clk = ~clk;   // 50 MHz

    msi_ind_notify #(.NUM_FN(NF)) uut (.*);

    // Model tables, written independently of the packed port vectors.
    int m_bound[NF]    = '{1, 1, 0, 1};
    int m_en[NF]       = '{1, 0, 0, 1};
    int m_isc[NF]      = '{5, 2, 0, 7};
    int m_ibase[NF]    = '{'h1000, 'h3000, 0, 'h4000};
    int m_ioff[NF]     = '{0, 0, 0, 13};
    int m_sbase[NF]    = '{'h2000, 'h3800, 0, 'h5000};
    int m_soff[NF]     = '{0, 0, 0, 21};

    typedef struct { longint addr; int mask; bit is_sum; int isc; } op_t;
    op_t ops[$];
    logic [7:0] mem_model [longint];

    int checks = 0, errors = 0;
    int irq_cnt = 0, err_cnt = 0, rsp_cnt = 0, memop_cnt = 0;
    bit exp_irq = 0, exp_err = 0, exp_rsp = 0;
    int exp_isc = 0, exp_eidx = 0;
    longint exp_eaddr = 0, exp_einfo = 0;
    int lat = 0, wait_cnt = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] rd_mem(input longint a);
        return mem_model.exists(a) ? mem_model[a] : 8'h00;
    endfunction

    // Reference model: compare every falling edge, then predict the next one.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(msi_ready == (ops.size() == 0), "R5", "msi_ready", msi_ready, ops.size() == 0);
            chk(mem_req == (ops.size() != 0), "R5", "mem_req", mem_req, ops.size() != 0);
            if (mem_req && ops.size() != 0) begin
                chk(mem_addr == ops[0].addr, ops[0].is_sum ? "R4" : "R3", "mem_addr", mem_addr, ops[0].addr);
                chk(mem_mask == ops[0].mask, ops[0].is_sum ? "R4" : "R3", "mem_mask", mem_mask, ops[0].mask);
            end
            chk(irq_pulse == exp_irq, "R7", "irq_pulse", irq_pulse, exp_irq);
            if (exp_irq) chk(irq_isc == exp_isc, "R7", "irq_isc", irq_isc, exp_isc);
            chk(err_valid == exp_err, "R8", "err_valid", err_valid, exp_err);
            if (exp_err) begin
                chk(err_code == 16'h0031, "R8", "err_code", err_code, 16'h0031);
                chk(err_index == exp_eidx, "R8", "err_index", err_index, exp_eidx);
                chk(err_addr == exp_eaddr, "R8", "err_addr", err_addr, exp_eaddr);
                chk(err_info == exp_einfo, "R8", "err_info", err_info, exp_einfo);
            end
            chk(rsp_valid == exp_rsp, "R10", "rsp_valid", rsp_valid, exp_rsp);
            if (exp_rsp) chk(rsp_data == 64'h0000_0000_FFFF_FFFF, "R10", "rsp_data", rsp_data, 64'hFFFF_FFFF);
            if (irq_pulse) irq_cnt++;
            if (err_valid) err_cnt++;
            if (rsp_valid) rsp_cnt++;

            exp_irq = 0; exp_err = 0; exp_rsp = 0;
            mem_ack = 1'b0;
            mem_old = 8'h5A;
            // Memory responder: OR at the design's address, return old byte.
            if (mem_req && ops.size() != 0) begin
                if (wait_cnt >= lat) begin
                    logic [7:0] old;
                    old = rd_mem(longint'(mem_addr));
                    mem_model[longint'(mem_addr)] = old | mem_mask;
                    mem_ack = 1'b1;
                    mem_old = old;
                    memop_cnt++;
                    if (ops[0].is_sum) begin
                        exp_irq = (old == 8'h00);
                        exp_isc = ops[0].isc;
                    end
                    void'(ops.pop_front());
                    wait_cnt = 0;
                    lat = (lat + 1) % 3;
                end else begin
                    wait_cnt++;
                end
            end
            // Access accepted at the coming rising edge.
            if (msi_valid && msi_ready) begin
                int idx, vec, ib, sb;
                idx = int'(msi_data[31:16]);
                vec = int'(msi_data[15:0]);
                if (!msi_write) begin
                    exp_rsp = 1;
                end else if (idx >= NF || m_bound[idx] == 0) begin
                    exp_err = 1;
                    exp_eidx = idx;
                    exp_eaddr = longint'(msi_addr);
                    exp_einfo = longint'(vec) << 16;
                end else if (m_en[idx] != 0) begin
                    ib = m_ioff[idx] + vec;
                    sb = m_soff[idx];
                    ops.push_back('{longint'(m_ibase[idx] + ib / 8), 8'h80 >> (ib % 8), 1'b0, m_isc[idx]});
                    ops.push_back('{longint'(m_sbase[idx] + sb / 8), 8'h80 >> (sb % 8), 1'b1, m_isc[idx]});
                end
            end
        end
    end

    // Offer one access and hold it until accepted.
    task automatic access(input bit wr, input logic [31:0] data, input logic [AW-1:0] addr);
        bit acc;
        @(posedge clk); #1;
        msi_valid = 1'b1; msi_write = wr; msi_data = data; msi_addr = addr;
        do begin
            @(negedge clk);
            acc = msi_ready;
            @(posedge clk);
        end while (!acc);
        #1 msi_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (10) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        int i0, e0, m0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(msi_ready == 1'b1, "R1", "ready after reset", msi_ready, 1);
        chk(mem_req == 1'b0 && irq_pulse == 1'b0 && err_valid == 1'b0 && rsp_valid == 1'b0,
            "R1", "strobes after reset", {mem_req, irq_pulse, err_valid, rsp_valid}, 0);

        // Function 0, vector 0: both bits at byte MSB, summary was clear.
        access(1, {16'd0, 16'd0}, 32'h0001_0000);
        settle();
        chk(rd_mem(32'h1000) == 8'h80, "R3", "fn0 vec0 indicator", rd_mem(32'h1000), 8'h80);
        chk(rd_mem(32'h2000) == 8'h80, "R4", "fn0 summary", rd_mem(32'h2000), 8'h80);
        chk(irq_cnt == 1, "R7", "irq on clear summary", irq_cnt, 1);

        // Vector 10: summary already set, so no further interrupt.
        access(1, {16'd0, 16'd10}, 32'h0001_0000);
        settle();
        chk(rd_mem(32'h1001) == 8'h20, "R3", "fn0 vec10 indicator", rd_mem(32'h1001), 8'h20);
        chk(irq_cnt == 1, "R7", "no irq on set summary", irq_cnt, 1);

        // Software clears the summary byte: the next write interrupts again.
        mem_model[32'h2000] = 8'h00;
        access(1, {16'd0, 16'd3}, 32'h0001_0000);
        settle();
        chk(irq_cnt == 2, "R7", "irq after summary cleared", irq_cnt, 2);

        // R2: index 3 from the upper half, vector 300 from the lower half.
        access(1, {16'd3, 16'd300}, 32'h0001_0000);
        settle();
        chk(rd_mem(32'h4027) == 8'h40, "R2", "fn3 vec300 indicator", rd_mem(32'h4027), 8'h40);
        chk(rd_mem(32'h5002) == 8'h04, "R4", "fn3 summary offset 21", rd_mem(32'h5002), 8'h04);
        chk(irq_cnt == 3, "R7", "fn3 irq", irq_cnt, 3);

        // R9: disabled function is dropped.
        i0 = irq_cnt; e0 = err_cnt; m0 = memop_cnt;
        access(1, {16'd1, 16'd4}, 32'h0001_0000);
        settle();
        chk(memop_cnt == m0, "R9", "no memory access", memop_cnt, m0);
        chk(irq_cnt == i0 && err_cnt == e0, "R9", "no irq or error", irq_cnt + err_cnt, i0 + e0);

        // R8: unbound slot and out-of-range index.
        m0 = memop_cnt;
        access(1, {16'd2, 16'h0042}, 32'h0001_0040);
        settle();
        chk(err_cnt == e0 + 1, "R8", "unbound slot error", err_cnt, e0 + 1);
        access(1, {16'd9, 16'hBEEF}, 32'h0001_0080);
        settle();
        chk(err_cnt == e0 + 2, "R8", "out of range error", err_cnt, e0 + 2);
        chk(memop_cnt == m0, "R8", "no memory access on error", memop_cnt, m0);

        // R10: read of the region.
        access(0, 32'h0, 32'h0001_0000);
        settle();
        chk(rsp_cnt == 1, "R10", "read response", rsp_cnt, 1);
        chk(memop_cnt == m0, "R10", "read makes no access", memop_cnt, m0);

        // R5: back-to-back writes; the second stalls behind the first.
        mem_model[32'h2000] = 8'h00;
        access(1, {16'd0, 16'd17}, 32'h0001_0000);
        access(1, {16'd0, 16'd18}, 32'h0001_0000);
        settle();
        chk(rd_mem(32'h1002) == 8'h60, "R5", "both vectors set", rd_mem(32'h1002), 8'h60);
        chk(irq_cnt == 4, "R7", "one irq for the pair", irq_cnt, 4);

        finished = 1;
        finish_run();
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R5 watchdog actual=hung expected=done");
            finish_run();
        end
    end

endmodule